// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation analog-to-digital converter. Software starts a conversion by writing a one to the GO bit. The block stops the sample switch and drives a trial code to an external DAC. It resolves one result bit per conversion-clock period, most significant bit first, by reading an external comparator. At the end it loads the result register, drops GO and raises a sticky completion flag. Until that moment the result register keeps showing the previous conversion's value.

The conversion clock is a divided copy of the system clock, with a ratio of 2, 8 or 32. It can instead come from a slow external tick, which stands in for an on-chip RC oscillator. The slow source adds one instruction cycle of start delay before the first conversion period. A conversion occupies 11 conversion-clock periods: 8 bit decisions followed by 3 tail periods. After completion the sample switch stays open for another 1.5 conversion-clock periods before sampling resumes. Software can abort a running conversion by writing GO to zero.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, go_o=0, irq_o=0, sample_o=1 and result_o=0.
- R2: A go_set_i pulse is accepted only while the block is idle (sample_o=1). From the next cycle go_o=1 and sample_o=0. A go_set_i pulse while go_o=1 or during the post-conversion gap has no effect.
- R3: The trial code starts at 8'h80. In each of the first 8 periods one bit is under trial, from bit 7 down to bit 0. At the end of that period the bit is kept when cmp_i=1 (the input is greater than or equal to the DAC code) and cleared otherwise, and the next lower bit is set.
- R4: clk_sel_i selects the conversion-clock period: 0 gives 2, 1 gives 8 and 2 gives 32 system cycles. In these modes irq_o and the new result appear exactly 11 periods after the edge that accepts go_set_i.
- R5: clk_sel_i=3 selects the slow source. go_o rises, then 4 system cycles pass before conversion starts. After that, each rc_tick_i pulse ends one period, and rc_tick_i pulses during the delay are ignored.
- R6: result_o holds its previous value while go_o=1. It is loaded on the same edge where go_o falls and irq_o rises.
- R7: After completion, sample_o returns to 1 after 3*div/2 system cycles in a divided mode, and after 2 rc_tick_i pulses in slow mode.
- R8: A go_clr_i pulse while go_o=1 aborts the conversion. On the next cycle go_o=0 and sample_o=1, result_o is unchanged and irq_o is not set.
- R9: irq_o stays set until an irq_clr_i pulse clears it.
- R10: clk_sel_i is captured when a conversion is accepted. Changing it during the conversion does not affect that conversion's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| go_set_i | input | 1 | Software write of GO=1 (start) |
| go_clr_i | input | 1 | Software write of GO=0 (abort) |
| irq_clr_i | input | 1 | Software clear of completion flag |
| clk_sel_i | input | 2 | Conversion-clock source select |
| rc_tick_i | input | 1 | Slow-source period tick |
| cmp_i | input | 1 | Comparator: analog input >= DAC code |
| trial_o | output | 8 | Trial code to the DAC |
| result_o | output | 8 | Result register |
| go_o | output | 1 | GO status, high while converting |
| sample_o | output | 1 | Sample switch closed |
| irq_o | output | 1 | Sticky conversion-complete flag |

## Verification
A wrong period count or divider ratio moves the fall of go_o and the rise of irq_o away from the exact 11-period point, so it is visible on the first conversion in the affected mode. A wrong bit position or keep/clear decision in the approximation register shows on trial_o within one period of the error. It also yields a wrong result_o at completion. Faults in the post-conversion gap or in the abort path show as sample_o returning a few cycles early or late, or as result_o or irq_o changing on an abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_CONV, ST_HOLD} seq_st_e;
  typedef enum logic [1:0] {
    CK_DIV_A = 2'd0,
    CK_DIV_B = 2'd1,
    CK_DIV_C = 2'd2,
    CK_SLOW  = 2'd3
  } ck_sel_e;
endpackage

// File: rtl/adc_tad_gen.sv
module adc_tad_gen
  import adc_seq_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  ck_sel_e    sel_i,
  input  logic       slow_tick_i,
  output logic       tick_o,
  output logic [1:0] half_inc_o
);
  localparam int MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int MAXD   = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
  localparam int CW     = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic [CW-1:0] cnt_q, lim, mid;
  logic          slow;

  always_comb begin
    unique case (sel_i)
      CK_DIV_A: begin lim = CW'(DIV_A - 1); mid = CW'(DIV_A / 2 - 1); end
      CK_DIV_B: begin lim = CW'(DIV_B - 1); mid = CW'(DIV_B / 2 - 1); end
      default:  begin lim = CW'(DIV_C - 1); mid = CW'(DIV_C / 2 - 1); end
    endcase
  end

  assign slow   = (sel_i == CK_SLOW);
  assign tick_o = run_i && (slow ? slow_tick_i : (cnt_q == lim));

  // half-period events drive the post-conversion gap; a slow tick is two halves
  always_comb begin
    half_inc_o = 2'd0;
    if (run_i) begin
      if (slow) half_inc_o = slow_tick_i ? 2'd2 : 2'd0;
      else if (cnt_q == lim || cnt_q == mid) half_inc_o = 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || slow)      cnt_q <= '0;
    else if (cnt_q == lim)        cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int N_BITS = 8,
  localparam int BW = (N_BITS > 2) ? $clog2(N_BITS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [BW-1:0]     pos_i,
  input  logic              cmp_i,
  output logic [N_BITS-1:0] trial_o
);
  logic [N_BITS-1:0] trial_q, trial_d;

  always_comb begin
    trial_d = trial_q;
    for (int i = 0; i < N_BITS; i++) begin
      if (i == int'(pos_i))          trial_d[i] = cmp_i;
      else if (i + 1 == int'(pos_i)) trial_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     trial_q <= '0;
    else if (load_i) trial_q <= {1'b1, {(N_BITS-1){1'b0}}};
    else if (step_i) trial_q <= trial_d;
  end

  assign trial_o = trial_q;
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int N_BITS      = 8,
  parameter int TAIL        = 3,
  parameter int DIV_A       = 2,
  parameter int DIV_B       = 8,
  parameter int DIV_C       = 32,
  parameter int START_DLY   = 4,
  parameter int HOLD_HALVES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_set_i,
  input  logic              go_clr_i,
  input  logic              irq_clr_i,
  input  logic [1:0]        clk_sel_i,
  input  logic              rc_tick_i,
  input  logic              cmp_i,
  output logic [N_BITS-1:0] trial_o,
  output logic [N_BITS-1:0] result_o,
  output logic              go_o,
  output logic              sample_o,
  output logic              irq_o
);
  localparam int N_PER = N_BITS + TAIL;
  localparam int PW    = $clog2(N_PER);
  localparam int BW    = (N_BITS > 2) ? $clog2(N_BITS) : 1;
  localparam int DW    = (START_DLY > 2) ? $clog2(START_DLY) : 1;
  localparam int HW    = $clog2(HOLD_HALVES + 3);

  seq_st_e           st_q;
  ck_sel_e           sel_q;
  logic [PW-1:0]     per_q;
  logic [DW-1:0]     dly_q;
  logic [HW-1:0]     hold_q, hold_sum;
  logic [N_BITS-1:0] result_q;
  logic              irq_q;
  logic              run, tick, bit_phase, last, accept, done;
  logic [1:0]        half_inc;
  logic [BW-1:0]     pos;

  assign run       = (st_q == ST_CONV) || (st_q == ST_HOLD);
  assign bit_phase = (st_q == ST_CONV) && (per_q < PW'(N_BITS));
  assign last      = (per_q == PW'(N_PER - 1));
  assign pos       = BW'(N_BITS - 1) - BW'(per_q);
  assign accept    = (st_q == ST_IDLE) && go_set_i;
  assign done      = (st_q == ST_CONV) && !go_clr_i && tick && last;
  assign hold_sum  = hold_q + HW'(half_inc);

  adc_tad_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_tad (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .sel_i       (sel_q),
    .slow_tick_i (rc_tick_i),
    .tick_o      (tick),
    .half_inc_o  (half_inc)
  );

  adc_sar_reg #(.N_BITS(N_BITS)) u_sar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .step_i  (bit_phase && tick),
    .pos_i   (pos),
    .cmp_i   (cmp_i),
    .trial_o (trial_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= CK_DIV_A;
      per_q  <= '0;
      dly_q  <= '0;
      hold_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_set_i) begin
          sel_q <= ck_sel_e'(clk_sel_i);
          per_q <= '0;
          dly_q <= '0;
          st_q  <= (ck_sel_e'(clk_sel_i) == CK_SLOW) ? ST_DELAY : ST_CONV;
        end
        ST_DELAY: begin
          if (go_clr_i)                          st_q  <= ST_IDLE;
          else if (dly_q == DW'(START_DLY - 1))  st_q  <= ST_CONV;
          else                                   dly_q <= dly_q + 1'b1;
        end
        ST_CONV: begin
          if (go_clr_i) st_q <= ST_IDLE;
          else if (tick) begin
            if (last) begin
              st_q   <= ST_HOLD;
              hold_q <= '0;
            end else begin
              per_q <= per_q + 1'b1;
            end
          end
        end
        default: begin
          if (half_inc != 2'd0) begin
            if (hold_sum >= HW'(HOLD_HALVES)) st_q   <= ST_IDLE;
            else                              hold_q <= hold_sum;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (done) result_q <= trial_o;
      if (done)           irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign result_o = result_q;
  assign irq_o    = irq_q;
  assign go_o     = (st_q == ST_DELAY) || (st_q == ST_CONV);
  assign sample_o = (st_q == ST_IDLE);
endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
  parameter int N_BITS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              go_clr_i,
  input logic              irq_clr_i,
  input logic [N_BITS-1:0] trial_o,
  input logic [N_BITS-1:0] result_o,
  input logic              go_o,
  input logic              sample_o,
  input logic              irq_o
);
  p_go_no_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> !sample_o);

  p_msb_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(go_o) |-> (trial_o == {1'b1, {(N_BITS-1){1'b0}}}));

  p_result_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $stable(result_o));

  p_irq_with_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $fell(go_o));

  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && go_clr_i) |=> (!go_o && sample_o && $stable(result_o)));

  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
endmodule

bind adc_sar_seq adc_sar_seq_chk #(.N_BITS(N_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .go_clr_i  (go_clr_i),
  .irq_clr_i (irq_clr_i),
  .trial_o   (trial_o),
  .result_o  (result_o),
  .go_o      (go_o),
  .sample_o  (sample_o),
  .irq_o     (irq_o)
);

// File: tb/adc_sar_seq_test.sv
module adc_sar_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go_set = 1'b0, go_clr = 1'b0, irq_clr = 1'b0, rc_tick = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] vin = 8'd0;
  logic [7:0] trial_o, result_o;
  logic       go_o, sample_o, irq_o, cmp;
  int         n_chk = 0, n_bad = 0;
  int         rc_ph = 0;

  always #2 clk = ~clk;

  assign cmp = (vin >= trial_o);

  adc_sar_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .go_set_i(go_set), .go_clr_i(go_clr),
    .irq_clr_i(irq_clr), .clk_sel_i(sel), .rc_tick_i(rc_tick), .cmp_i(cmp),
    .trial_o(trial_o), .result_o(result_o), .go_o(go_o),
    .sample_o(sample_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // slow source: one tick every 5 system cycles
  always @(negedge clk) begin
    rc_ph   = (rc_ph + 1) % 5;
    rc_tick = (rc_ph == 0);
  end

  // behavioural reference: 0 idle, 1 start delay, 2 converting, 3 gap
  int   m_st, m_cyc, m_tk, m_div;
  bit   m_rc, m_irq;
  logic [7:0] m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cyc = 0; m_tk = 0; m_div = 2; m_rc = 0; m_irq = 0; m_res = 0;
    end else begin
      if (irq_clr) m_irq = 0;
      case (m_st)
        0: if (go_set) begin
          m_rc  = (sel == 2'd3);
          m_div = (sel == 2'd0) ? 2 : (sel == 2'd1) ? 8 : 32;
          m_cyc = 0; m_tk = 0;
          m_st  = m_rc ? 1 : 2;
        end
        1: if (go_clr) m_st = 0;
           else begin
             m_cyc++;
             if (m_cyc == 4) begin m_st = 2; m_cyc = 0; m_tk = 0; end
           end
        2: if (go_clr) m_st = 0;
           else begin
             m_cyc++;
             if (m_rc && rc_tick) m_tk++;
             if (m_rc ? (m_tk == 11) : (m_cyc == 11 * m_div)) begin
               m_st = 3; m_res = vin; m_irq = 1; m_cyc = 0; m_tk = 0;
             end
           end
        default: begin
          m_cyc++;
          if (m_rc && rc_tick) m_tk++;
          if (m_rc ? (m_tk == 2) : (m_cyc == 3 * m_div / 2)) m_st = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(go_o == (m_st == 1 || m_st == 2), "R2 go_o", go_o, (m_st == 1 || m_st == 2));
      chk(sample_o == (m_st == 0), "R7 sample_o", sample_o, (m_st == 0));
      chk(irq_o == m_irq, "R9 irq_o", irq_o, m_irq);
      chk(result_o == m_res, "R6 result_o", result_o, m_res);
      if (m_st == 2) begin
        int p, b, e, v;
        v = vin;
        p = m_rc ? m_tk : m_cyc / m_div;
        if (p < 8) begin
          b = 7 - p;
          e = ((v >> (b + 1)) << (b + 1)) | (1 << b);
        end else e = v;
        chk(trial_o == e[7:0], "R3 trial_o", trial_o, e);
      end
    end
  end

  task automatic conv(input logic [1:0] s, input logic [7:0] v, input bit poke, output int k);
    @(negedge clk); vin = v; sel = s; go_set = 1'b1;
    @(negedge clk); go_set = 1'b0; k = 0;
    while (!irq_o) begin
      @(negedge clk); k++;
      if (poke && k == 5) begin go_set = 1'b1; sel = s ^ 2'b01; end
      if (poke && k == 6) go_set = 1'b0;
    end
    while (!sample_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b1, "R9 flag held", irq_o, 1);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq_o == 1'b0, "R9 flag cleared", irq_o, 0);
    sel = s;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(go_o == 0 && irq_o == 0 && sample_o == 1 && result_o == 0,
        "R1 reset state", {go_o, irq_o, sample_o}, 3'b001);

    conv(2'd0, 8'hA5, 0, k);
    chk(k == 22, "R4 div2 length", k, 22);
    chk(result_o == 8'hA5, "R6 result div2", result_o, 8'hA5);

    conv(2'd1, 8'h00, 1, k);
    chk(k == 88, "R10 R2 div8 length with mid-run writes", k, 88);
    chk(result_o == 8'h00, "R3 result zero", result_o, 0);

    conv(2'd2, 8'hFF, 0, k);
    chk(k == 352, "R4 div32 length", k, 352);
    chk(result_o == 8'hFF, "R3 result full scale", result_o, 8'hFF);

    conv(2'd0, 8'h80, 0, k);
    chk(result_o == 8'h80, "R3 equal keeps bit", result_o, 8'h80);
    conv(2'd0, 8'h7F, 0, k);
    chk(result_o == 8'h7F, "R3 below msb", result_o, 8'h7F);

    conv(2'd3, 8'h5A, 0, k);
    chk(k >= 15, "R5 slow start delay", k, 15);
    chk(result_o == 8'h5A, "R5 slow result", result_o, 8'h5A);

    conv(2'd3, 8'hC3, 1, k);
    chk(result_o == 8'hC3, "R10 slow result after sel change", result_o, 8'hC3);

    // abort mid conversion
    @(negedge clk); vin = 8'h3C; sel = 2'd1; go_set = 1'b1;
    @(negedge clk); go_set = 1'b0;
    repeat (20) @(negedge clk);
    go_clr = 1'b1;
    @(negedge clk); go_clr = 1'b0;
    chk(go_o == 0 && sample_o == 1, "R8 abort stops", {go_o, sample_o}, 2'b01);
    chk(result_o == 8'hC3, "R8 abort keeps result", result_o, 8'hC3);
    repeat (100) @(negedge clk);
    chk(irq_o == 0, "R8 abort no flag", irq_o, 0);
    chk(result_o == 8'hC3, "R8 result still old", result_o, 8'hC3);

    // abort during slow start delay
    @(negedge clk); sel = 2'd3; go_set = 1'b1;
    @(negedge clk); go_set = 1'b0; go_clr = 1'b1;
    @(negedge clk); go_clr = 1'b0;
    chk(go_o == 0 && sample_o == 1, "R8 abort in delay", {go_o, sample_o}, 2'b01);
    repeat (40) @(negedge clk);
    chk(irq_o == 0 && result_o == 8'hC3, "R5 R8 no completion", irq_o, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule